// File: doc/BRIEF.md
# Exception and Interrupt Entry Unit

This unit is the privileged-state corner of a small 32-bit MIPS-like core. It keeps four control words: a processor status word, an exception cause word, a saved return address and a fixed revision identifier. When the pipeline raises an exception, or when an external interrupt is both pending and allowed, the unit records why the entry happened. It saves the return address and pushes the interrupt-enable/mode pair stack inside the status word. It then issues a one-cycle redirect that carries the selected exception vector.

Interrupts come from an outside controller as a pending word and a mask word. The unit takes an interrupt entry only when their bitwise AND is nonzero and two status bits allow it. Software reads and writes the control words through a simple select-based port. When the faulting instruction is a coprocessor-2 command word, a side flag asks the datapath to finish that command before the jump.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, redirect_pc is 0xBFC00000 and redirect and cop2_finish are low. Status reads 0x10900000, cause and return address read 0, and the revision word reads 0x00000002.
- R2: On entry, cause bits 9:8 keep their old value and the 5-bit exc_code is placed in cause bits 6:2. Every other cause bit is cleared, except bit 31 as given by R3.
- R3: On a synchronous entry with exc_in_delay high, cause bit 31 is set and the return address becomes cur_pc minus 4, modulo 2^32. With exc_in_delay low, bit 31 is clear and the return address is cur_pc.
- R4: On the clock cycle after an entry, redirect_pc is 0xBFC00180 if status bit 22 was set at entry, and 0x80000080 otherwise.
- R5: On entry, status bits 5:0 become the old bits 3:0 shifted up by two, so bits 1:0 become zero. Status bits 31:6 are unchanged.
- R6: An interrupt entry occurs when (irq_pending & irq_mask) is nonzero and status bits 10 and 0 are both 1. With either status bit at 0, or with an empty AND, no redirect occurs.
- R7: An interrupt entry writes cause as (old cause & 0x300) | 0x400. Bit 10 is set, bits 6:2 and bit 31 are zero, and the return address is cur_pc.
- R8: cop2_finish pulses together with redirect when fault_op (instruction bits 31:25) equals 0x25 at entry. It stays low for any other value.
- R9: When exc_req and an allowed interrupt coincide, a single synchronous entry is taken and cause carries exc_code.
- R10: The register port uses selects 0 = status, 1 = cause, 2 = return address, 3 = revision. Writes to selects 0 to 2 take effect on the next cycle. A write to select 3 has no effect.
- R11: A register write in the same cycle as an entry is discarded, and the entry values are stored.
- R12: redirect is high for exactly the one cycle after each entry. After an interrupt entry no further interrupt entry occurs while status bit 0 stays 0, even with the interrupt still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_pc | input | 32 | Address of the faulting or interrupted instruction |
| exc_req | input | 1 | Synchronous exception request, one cycle per event |
| exc_code | input | 5 | Exception code for a synchronous request |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| fault_op | input | 7 | Bits 31:25 of the instruction at cur_pc |
| irq_pending | input | IRQ_W | Pending word from the interrupt controller |
| irq_mask | input | IRQ_W | Mask word from the interrupt controller |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register write select |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register read select |
| reg_rd_data | output | 32 | Register read data, combinational |
| redirect | output | 1 | One-cycle program counter redirect strobe |
| redirect_pc | output | 32 | New program counter, valid with redirect |
| cop2_finish | output | 1 | Ask datapath to complete a coprocessor-2 command |

## Verification
The checks assume that exc_req is a single-cycle pulse per event, and that exc_in_delay carries meaning only while exc_req is high. They also assume that inputs change only between clock edges. The stimulus follows this rule by driving every input on the falling edge and dropping exc_req right after the rising edge that takes it. It keeps the pending-and-mask AND at zero whenever a test writes a status word that enables interrupts, so that no entry starts unplanned. Interrupt tests change the mask only at chosen points.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_REVID  = 2'd3
  } cp0_sel_e;

  localparam int ST_BOOTVEC  = 22;
  localparam int ST_IRQ_GATE = 10;
  localparam int ST_IRQ_EN   = 0;
  localparam int CA_DELAY    = 31;

  localparam logic [XLEN-1:0] CA_KEEP_MASK = 32'h0000_0300;
  localparam logic [XLEN-1:0] CA_IRQ_VALUE = 32'h0000_0400;
  localparam logic [XLEN-1:0] RST_PC       = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] RST_STATUS   = 32'h1090_0000;
  localparam logic [XLEN-1:0] REVID_VALUE  = 32'h0000_0002;
  localparam logic [XLEN-1:0] VEC_BOOT     = 32'hBFC0_0180;
  localparam logic [XLEN-1:0] VEC_NORMAL   = 32'h8000_0080;
  localparam logic [6:0]      COP2_CMD_OP  = 7'h25;

  function automatic logic [XLEN-1:0] push_mode_stack(input logic [XLEN-1:0] s);
    return {s[XLEN-1:6], s[3:0], 2'b00};
  endfunction
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int IRQ_W = 16
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] mask_i,
  input  logic             gate_i,
  input  logic             ie_i,
  output logic             irq_o
);
  logic [IRQ_W-1:0] live;

  assign live  = pend_i & mask_i;
  assign irq_o = (|live) & gate_i & ie_i;
endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              irq_entry_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bd_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              wr_en_i,
  input  cp0_sel_e          wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  cp0_sel_e          rd_sel_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              st_bev_o,
  output logic              st_gate_o,
  output logic              st_ie_o
);
  logic [XLEN-1:0] status_q, status_d;
  logic [XLEN-1:0] cause_q,  cause_d;
  logic [XLEN-1:0] epc_q,    epc_d;
  logic            ld_en;
  logic [XLEN-1:0] code_field;

  assign code_field = {{(XLEN-CODE_W-2){1'b0}}, code_i, 2'b00};
  assign ld_en      = enter_i | wr_en_i;

  always_comb begin
    status_d = status_q;
    cause_d  = cause_q;
    epc_d    = epc_q;
    if (enter_i) begin
      status_d = push_mode_stack(status_q);
      cause_d  = (cause_q & CA_KEEP_MASK) | (irq_entry_i ? CA_IRQ_VALUE : code_field);
      if (bd_i) begin
        cause_d[CA_DELAY] = 1'b1;
        epc_d             = pc_i - 32'd4;
      end else begin
        epc_d = pc_i;
      end
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_STATUS: status_d = wr_data_i;
        SEL_CAUSE:  cause_d  = wr_data_i;
        SEL_EPC:    epc_d    = wr_data_i;
        SEL_REVID:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
      cause_q  <= '0;
      epc_q    <= '0;
    end else if (ld_en) begin
      status_q <= status_d;
      cause_q  <= cause_d;
      epc_q    <= epc_d;
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_STATUS: rd_data_o = status_q;
      SEL_CAUSE:  rd_data_o = cause_q;
      SEL_EPC:    rd_data_o = epc_q;
      SEL_REVID:  rd_data_o = REVID_VALUE;
    endcase
  end

  assign st_bev_o  = status_q[ST_BOOTVEC];
  assign st_gate_o = status_q[ST_IRQ_GATE];
  assign st_ie_o   = status_q[ST_IRQ_EN];

  p_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00}) &&
                (status_q[31:6] == $past(status_q[31:6])));

  p_epc_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && !bd_i) |=> (epc_q == $past(pc_i)) && !cause_q[CA_DELAY]);

  p_cause_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> cause_q[9:8] == $past(cause_q[9:8]));

  p_irq_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && irq_entry_i) |=> cause_q[10] && (cause_q[6:2] == '0) && !cause_q[CA_DELAY]);

  p_sync_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && !irq_entry_i) |=> cause_q[6:2] == $past(code_i));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int IRQ_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_in_delay,
  input  logic [6:0]        fault_op,
  input  logic [IRQ_W-1:0]  irq_pending,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [XLEN-1:0]   reg_wr_data,
  input  logic [1:0]        reg_rd_sel,
  output logic [XLEN-1:0]   reg_rd_data,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              cop2_finish
);
  logic              rst_n_s;
  logic              irq_raw;
  logic              enter;
  logic              irq_entry;
  logic              bd_eff;
  logic [CODE_W-1:0] code_eff;
  logic              st_bev, st_gate, st_ie;
  logic              redirect_q, redirect_d;
  logic [XLEN-1:0]   target_q, target_d;
  logic              cop2_q, cop2_d;

  exc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  exc_irq_gate #(.IRQ_W(IRQ_W)) u_irq_gate (
    .pend_i (irq_pending),
    .mask_i (irq_mask),
    .gate_i (st_gate),
    .ie_i   (st_ie),
    .irq_o  (irq_raw)
  );

  // synchronous requests win over interrupts
  assign enter     = exc_req | irq_raw;
  assign irq_entry = ~exc_req;
  assign bd_eff    = exc_req & exc_in_delay;
  assign code_eff  = exc_req ? exc_code : '0;

  exc_cp0_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .enter_i     (enter),
    .irq_entry_i (irq_entry),
    .code_i      (code_eff),
    .bd_i        (bd_eff),
    .pc_i        (cur_pc),
    .wr_en_i     (reg_wr_en),
    .wr_sel_i    (cp0_sel_e'(reg_wr_sel)),
    .wr_data_i   (reg_wr_data),
    .rd_sel_i    (cp0_sel_e'(reg_rd_sel)),
    .rd_data_o   (reg_rd_data),
    .st_bev_o    (st_bev),
    .st_gate_o   (st_gate),
    .st_ie_o     (st_ie)
  );

  always_comb begin
    redirect_d = enter;
    cop2_d     = enter && (fault_op == COP2_CMD_OP);
    target_d   = target_q;
    if (enter) target_d = st_bev ? VEC_BOOT : VEC_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      redirect_q <= 1'b0;
      cop2_q     <= 1'b0;
      target_q   <= RST_PC;
    end else begin
      redirect_q <= redirect_d;
      cop2_q     <= cop2_d;
      if (enter) target_q <= target_d;
    end
  end

  assign redirect    = redirect_q;
  assign redirect_pc = target_q;
  assign cop2_finish = cop2_q;

  p_take_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    enter |=> redirect);

  p_vec_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    enter |=> redirect_pc == ($past(st_bev) ? VEC_BOOT : VEC_NORMAL));

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_raw && !exc_req) |=> !irq_raw);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_raw |-> (|(irq_pending & irq_mask)) && st_ie && st_gate);

  p_cop2_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    cop2_finish |-> redirect);
endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
  localparam int IRQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [31:0]      cur_pc;
  logic             exc_req;
  logic [4:0]       exc_code;
  logic             exc_in_delay;
  logic [6:0]       fault_op;
  logic [IRQ_W-1:0] irq_pending, irq_mask;
  logic             reg_wr_en;
  logic [1:0]       reg_wr_sel;
  logic [31:0]      reg_wr_data;
  logic [1:0]       reg_rd_sel;
  logic [31:0]      reg_rd_data;
  logic             redirect;
  logic [31:0]      redirect_pc;
  logic             cop2_finish;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  exc_entry_unit #(.IRQ_W(IRQ_W)) i_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_req(exc_req),
    .exc_code(exc_code), .exc_in_delay(exc_in_delay), .fault_op(fault_op),
    .irq_pending(irq_pending), .irq_mask(irq_mask), .reg_wr_en(reg_wr_en),
    .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel),
    .reg_rd_data(reg_rd_data), .redirect(redirect), .redirect_pc(redirect_pc),
    .cop2_finish(cop2_finish)
  );

  // status, cause, pc, code, delay-slot
  localparam logic [101:0] VEC_TBL [6] = '{
    {32'h1090_0000, 32'h0000_0000, 32'h8000_1000, 5'h08, 1'b0},
    {32'h0000_000D, 32'hFFFF_FFFF, 32'h8001_0004, 5'h04, 1'b1},
    {32'h0040_003F, 32'h0000_0100, 32'h0000_0010, 5'h1F, 1'b1},
    {32'hFFBF_FFFF, 32'h0000_0200, 32'hBFC0_0000, 5'h00, 1'b0},
    {32'h0000_0005, 32'h0000_007C, 32'h0000_0000, 5'h0C, 1'b1},
    {32'h0040_0002, 32'h8000_0300, 32'h1234_5678, 5'h09, 1'b0}
  };

  function automatic logic [31:0] f_status(input logic [31:0] s);
    return {s[31:6], s[3:0], 2'b00};
  endfunction
  function automatic logic [31:0] f_cause(input logic [31:0] old, input logic [4:0] c, input logic bd);
    return (old & 32'h300) | ({27'b0, c} << 2) | (bd ? 32'h8000_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] f_vec(input logic [31:0] s);
    return s[22] ? 32'hBFC0_0180 : 32'h8000_0080;
  endfunction
  function automatic logic [31:0] f_epc(input logic [31:0] pc, input logic bd);
    return bd ? pc - 32'd4 : pc;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    reg_rd_sel = sel;
    #1;
    val = reg_rd_data;
  endtask

  task automatic do_entry(input logic [31:0] pc, input logic [4:0] c, input logic bd, input logic [6:0] op);
    @(negedge clk);
    cur_pc = pc; exc_code = c; exc_in_delay = bd; fault_op = op; exc_req = 1'b1;
    @(posedge clk);
    #1;
    exc_req = 1'b0; exc_in_delay = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++; ntests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cur_pc = '0; exc_req = 0; exc_code = '0; exc_in_delay = 0;
    fault_op = '0; irq_pending = '0; irq_mask = '0; reg_wr_en = 0;
    reg_wr_sel = '0; reg_wr_data = '0; reg_rd_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 redirect_pc", redirect_pc, 32'hBFC0_0000);
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 cop2_finish", {31'b0, cop2_finish}, 32'h0);
    rd(2'd0, v); chk("R1 status", v, 32'h1090_0000);
    rd(2'd1, v); chk("R1 cause", v, 32'h0);
    rd(2'd2, v); chk("R1 epc", v, 32'h0);
    rd(2'd3, v); chk("R1 revid", v, 32'h2);

    // table walk: R2 R3 R4 R5 R12
    for (int i = 0; i < 6; i++) begin
      logic [101:0] e;
      logic [31:0] st, ca, pc;
      logic [4:0]  c;
      logic        bd;
      e = VEC_TBL[i];
      st = e[101:70]; ca = e[69:38]; pc = e[37:6]; c = e[5:1]; bd = e[0];
      reg_write(2'd0, st);
      reg_write(2'd1, ca);
      do_entry(pc, c, bd, 7'h00);
      chk("R12 redirect pulse", {31'b0, redirect}, 32'h1);
      chk("R4 vector", redirect_pc, f_vec(st));
      rd(2'd0, v); chk("R5 status stack", v, f_status(st));
      rd(2'd1, v); chk("R2 cause", v, f_cause(ca, c, bd));
      rd(2'd2, v); chk("R3 epc", v, f_epc(pc, bd));
      @(posedge clk); #1;
      chk("R12 redirect drop", {31'b0, redirect}, 32'h0);
    end

    // R6 R7 interrupt entry, R12 hold-off
    reg_write(2'd1, 32'h0000_0300);
    reg_write(2'd0, 32'h0000_0401);
    irq_pending = 16'h0004; cur_pc = 32'h8000_2000;
    @(negedge clk); irq_mask = 16'h0004;
    @(posedge clk); #1;
    chk("R6 irq redirect", {31'b0, redirect}, 32'h1);
    chk("R6 irq vector", redirect_pc, 32'h8000_0080);
    rd(2'd1, v); chk("R7 irq cause", v, 32'h0000_0700);
    rd(2'd2, v); chk("R7 irq epc", v, 32'h8000_2000);
    rd(2'd0, v); chk("R5 irq status", v, 32'h0000_0404);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R12 irq held off", {31'b0, redirect}, 32'h0);
    end

    // R6 gate bits: bit10 clear, bit0 clear, empty AND
    irq_mask = '0;
    reg_write(2'd0, 32'h0000_0001);
    irq_mask = 16'h0004;
    repeat (2) @(posedge clk); #1;
    chk("R6 gate bit10 clear", {31'b0, redirect}, 32'h0);
    irq_mask = '0;
    reg_write(2'd0, 32'h0000_0400);
    irq_mask = 16'h0004;
    repeat (2) @(posedge clk); #1;
    chk("R6 enable bit0 clear", {31'b0, redirect}, 32'h0);
    irq_mask = 16'h0008;
    reg_write(2'd0, 32'h0000_0401);
    repeat (2) @(posedge clk); #1;
    chk("R6 empty and", {31'b0, redirect}, 32'h0);

    // R9 priority: exception and interrupt together
    irq_mask = '0;
    reg_write(2'd1, 32'h0);
    @(negedge clk);
    irq_mask = 16'h0004; cur_pc = 32'h8000_3000; exc_code = 5'h0A; exc_req = 1'b1;
    @(posedge clk); #1;
    exc_req = 1'b0;
    chk("R9 redirect", {31'b0, redirect}, 32'h1);
    rd(2'd1, v); chk("R9 cause code", v, 32'h0000_0028);
    @(posedge clk); #1;
    chk("R9 single redirect", {31'b0, redirect}, 32'h0);
    irq_mask = '0; irq_pending = '0;

    // R10 write and read back, revision read-only
    reg_write(2'd2, 32'h1234_5678);
    rd(2'd2, v); chk("R10 epc write", v, 32'h1234_5678);
    reg_write(2'd3, 32'h0000_0000);
    rd(2'd3, v); chk("R10 revid read-only", v, 32'h2);

    // R11 write collides with entry
    reg_write(2'd0, 32'h0);
    @(negedge clk);
    cur_pc = 32'h0040_0000; exc_code = 5'h01; exc_req = 1'b1;
    reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    exc_req = 1'b0; reg_wr_en = 1'b0;
    rd(2'd2, v); chk("R11 epc override", v, 32'h0040_0000);

    // R8 coprocessor-2 command flag
    do_entry(32'h8000_4000, 5'h02, 1'b0, 7'h25);
    chk("R8 cop2 with redirect", {31'b0, cop2_finish}, 32'h1);
    @(posedge clk); #1;
    chk("R8 cop2 one cycle", {31'b0, cop2_finish}, 32'h0);
    do_entry(32'h8000_4004, 5'h02, 1'b0, 7'h24);
    chk("R8 cop2 other opcode", {31'b0, cop2_finish}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule